// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the controller end of a byte-wide host mailbox with two I/O locations: a command/status location and a data location. A host write to either location latches the byte and raises the input-buffer-full flag. After a configurable number of cycles the controller takes the byte in, clears that flag and acts on it. Two commands are decoded. One reads a byte from an internal 256-byte register RAM. The other writes a byte into that RAM. Each runs as a short fixed handshake: command first, then address, then (for a write) data. The host paces every step by polling two flags in the status byte.

The sequencer is one state machine with four states. `ST_IDLE` waits for a command. `ST_RD_ADDR` waits for the read address. `ST_WR_ADDR` waits for the write address. `ST_WR_DATA` waits for the write data. These transitions happen on every consumed byte:
- A command byte of 0x88 moves to `ST_RD_ADDR`. A command byte of 0x89 moves to `ST_WR_ADDR`. Any other command byte returns to `ST_IDLE`.
- A data byte moves `ST_RD_ADDR` to `ST_IDLE`, loads the output byte and sets output-buffer-full.
- A data byte moves `ST_WR_ADDR` to `ST_WR_DATA` and holds the address.
- A data byte moves `ST_WR_DATA` to `ST_IDLE` and writes the RAM.
- A data byte in `ST_IDLE` stays in `ST_IDLE` and is dropped.

Top module: `ec_host_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00, a data-location read returns 0x00, and every RAM byte reads back as 0x00.
- R2: A host write to either location sets input-buffer-full (status bit 1) at the next clock edge. The flag stays set for exactly CONSUME_DLY cycles, then clears if no further write arrives.
- R3: Command 0x88 followed by an address byte on the data location loads the RAM byte at that address. Output-buffer-full (status bit 0) sets at the same edge at which input-buffer-full clears for the address byte.
- R4: Location select 1 is the command/status location (one above the data location) and select 0 is the data location. Status bits 7..2 read as zero. A host read strobe on the data location returns the output byte and clears output-buffer-full at that edge.
- R5: Command 0x89, then an address byte, then a data byte (each on the data location) stores the data byte at that address.
- R6: A command byte consumed while a sequence is open abandons that sequence and is decoded as a new command. A write abandoned after its address alters no RAM byte.
- R7: Any command byte other than 0x88 and 0x89 is consumed: input-buffer-full clears after CONSUME_DLY cycles, output-buffer-full stays clear, and the data bytes that follow are dropped.
- R8: A data-location byte consumed with no sequence open (state `ST_IDLE`) is dropped and changes no RAM byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Location select: 1 command/status, 0 data |
| host_wr | input | 1 | One-cycle host write strobe |
| host_rd | input | 1 | One-cycle host read strobe (acts on the data location) |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte (select 1) or output byte (select 0) |

## Verification
The assertions assume the host follows the handshake. It writes only while input-buffer-full is clear, and it strobes a data-location read only while output-buffer-full is set and input-buffer-full is clear. Under those conditions every flag edge has a single cause. The bench keeps within these limits by polling the status byte after every write until input-buffer-full drops. It issues a data read only after seeing output-buffer-full set. Each strobe is held for exactly one cycle.

// File: rtl/ecmb_pkg.sv
package ecmb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_WR_ADDR,
        ST_WR_DATA
    } ecmb_state_e;

    localparam logic [7:0] CMD_RAM_RD = 8'h88;
    localparam logic [7:0] CMD_RAM_WR = 8'h89;
endpackage

// File: rtl/ecmb_inbuf.sv
module ecmb_inbuf #(
    parameter int DW          = 8,
    parameter int CONSUME_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          wr_port,
    input  logic [DW-1:0] wr_byte,
    output logic          ibf,
    output logic          consume,
    output logic          byte_port,
    output logic [DW-1:0] byte_val
);
    localparam int CW = $clog2(CONSUME_DLY + 1);
    localparam logic [CW-1:0] LOAD = CW'(CONSUME_DLY - 1);

    logic [CW-1:0] cnt;

    assign consume = ibf && (cnt == '0) && !wr_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ibf       <= 1'b0;
            cnt       <= '0;
            byte_port <= 1'b0;
            byte_val  <= '0;
        end else if (wr_stb) begin
            ibf       <= 1'b1;
            cnt       <= LOAD;
            byte_port <= wr_port;
            byte_val  <= wr_byte;
        end else if (consume) begin
            ibf <= 1'b0;
        end else if (ibf) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ecmb_regram.sv
module ecmb_regram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    assign rdata = mem[raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/ecmb_seq.sv
module ecmb_seq
    import ecmb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          consume,
    input  logic          byte_port,
    input  logic [DW-1:0] byte_val,
    input  logic          rd_data_stb,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] ram_raddr,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata,
    output logic          obf,
    output logic [DW-1:0] outbuf
);
    ecmb_state_e st, nxt;
    logic [AW-1:0] addr_q;
    logic          data_in;

    assign data_in   = consume && !byte_port;
    assign ram_raddr = byte_val[AW-1:0];
    assign ram_waddr = addr_q;
    assign ram_wdata = byte_val;
    assign ram_we    = data_in && (st == ST_WR_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (consume && byte_port) begin
            case (byte_val)
                CMD_RAM_RD: nxt = ST_RD_ADDR;
                CMD_RAM_WR: nxt = ST_WR_ADDR;
                default:    nxt = ST_IDLE;
            endcase
        end else if (data_in) begin
            unique case (st)
                ST_IDLE:    nxt = ST_IDLE;
                ST_RD_ADDR: nxt = ST_IDLE;
                ST_WR_ADDR: nxt = ST_WR_DATA;
                ST_WR_DATA: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            obf    <= 1'b0;
            outbuf <= '0;
        end else begin
            if (data_in && st == ST_WR_ADDR) addr_q <= byte_val[AW-1:0];
            if (data_in && st == ST_RD_ADDR) begin
                outbuf <= ram_rdata;
                obf    <= 1'b1;
            end else if (rd_data_stb) begin
                obf <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ec_host_mailbox.sv
module ec_host_mailbox #(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int CONSUME_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    logic          ibf, obf, consume, byte_port, ram_we;
    logic [DW-1:0] byte_val, ram_rdata, ram_wdata, outbuf;
    logic [AW-1:0] ram_raddr, ram_waddr;

    ecmb_inbuf #(.DW(DW), .CONSUME_DLY(CONSUME_DLY)) u_inbuf (
        .clk(clk), .rst_n(rst_n), .wr_stb(host_wr), .wr_port(host_sel),
        .wr_byte(host_wdata), .ibf(ibf), .consume(consume),
        .byte_port(byte_port), .byte_val(byte_val)
    );

    ecmb_regram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr),
        .wdata(ram_wdata), .raddr(ram_raddr), .rdata(ram_rdata)
    );

    ecmb_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .consume(consume), .byte_port(byte_port),
        .byte_val(byte_val), .rd_data_stb(host_rd && !host_sel),
        .ram_rdata(ram_rdata), .ram_raddr(ram_raddr), .ram_we(ram_we),
        .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .obf(obf), .outbuf(outbuf)
    );

    assign host_rdata = host_sel ? {{(DW-2){1'b0}}, ibf, obf} : outbuf;
endmodule

// File: rtl/ecmb_checker.sv
module ecmb_checker #(
    parameter int CONSUME_DLY = 2
) (
    input logic clk,
    input logic rst_n,
    input logic host_sel,
    input logic host_wr,
    input logic host_rd,
    input logic ibf,
    input logic obf
);
    localparam int RW = $clog2(CONSUME_DLY + 2);
    localparam logic [RW-1:0] LIMIT = RW'(CONSUME_DLY);

    logic [RW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run <= '0;
        else if (host_wr) run <= RW'(1);
        else if (ibf)     run <= run + 1'b1;
        else              run <= '0;
    end

    AST_IBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ibf); // R2
    AST_IBF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ibf |-> (run >= RW'(1) && run <= LIMIT)); // R2
    AST_IBF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && run == LIMIT && !host_wr) |=> !ibf); // R2
    AST_OBF_AT_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(obf) |-> $fell(ibf)); // R3
    AST_OBF_DROP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_sel && !ibf) |=> !obf); // R4
endmodule

bind ec_host_mailbox ecmb_checker #(.CONSUME_DLY(CONSUME_DLY)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .ibf(ibf), .obf(obf)
);

// File: tb/tb_ec_host_mailbox.sv
module tb_ec_host_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b1, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    ec_host_mailbox #(.CONSUME_DLY(DLY)) dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic status_is(string tag, logic [7:0] exp);
        host_sel = 1'b1;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic host_write(bit sel, logic [7:0] b);
        @(negedge clk);
        host_sel = sel; host_wdata = b; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 1'b1;
    endtask

    task automatic wait_ibf(output int cyc);
        cyc = 0;
        host_sel = 1'b1;
        forever begin
            #1;
            if (!host_rdata[1] || cyc > 1000) break;
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic put(bit sel, logic [7:0] b);
        int c;
        host_write(sel, b);
        wait_ibf(c);
    endtask

    task automatic data_read(logic [7:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; host_sel = 1'b1;
        status_is("R4 OBF cleared by data read", 8'h00);
    endtask

    task automatic ram_write(logic [7:0] a, logic [7:0] d);
        put(1'b1, 8'h89); put(1'b0, a); put(1'b0, d);
    endtask

    task automatic ram_read(logic [7:0] a, logic [7:0] exp, string tag);
        put(1'b1, 8'h88); put(1'b0, a);
        status_is("R3 OBF set as IBF clears", 8'h01);
        data_read(exp, tag);
    endtask

    // monitor: pops the expected byte for each data-location read
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (host_rd && !host_sel) begin
                if (exp_q.size() == 0) begin
                    check("R4 unexpected data read", host_rdata, 8'hxx);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, host_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        status_is("R1 status after reset", 8'h00);
        host_sel = 1'b0; #1;
        check("R1 output byte after reset", host_rdata, 8'h00);
        host_sel = 1'b1;
        ram_read(8'h80, 8'h00, "R1 RAM zero after reset");

        // R2 flag timing
        host_write(1'b1, 8'h89);
        status_is("R2 IBF set after command write", 8'h02);
        wait_ibf(c);
        check("R2 IBF hold cycles", 8'(c), 8'(DLY));
        host_write(1'b0, 8'h10);
        status_is("R2 IBF set after data write", 8'h02);
        wait_ibf(c);
        check("R2 IBF hold cycles data", 8'(c), 8'(DLY));
        put(1'b0, 8'hA5);

        // R5 writes, R3 reads
        ram_write(8'h00, 8'h3C);
        ram_write(8'hFF, 8'hC3);
        ram_read(8'h10, 8'hA5, "R5 readback 10");
        ram_read(8'h00, 8'h3C, "R5 readback 00");
        ram_read(8'hFF, 8'hC3, "R3 readback FF");

        // R6 abort
        put(1'b1, 8'h89); put(1'b0, 8'h20);
        put(1'b1, 8'h88); put(1'b0, 8'h10);
        status_is("R6 new command took over", 8'h01);
        data_read(8'hA5, "R6 read after abort");
        ram_read(8'h20, 8'h00, "R6 abandoned write left RAM");

        // R7 unknown command
        host_write(1'b1, 8'h55);
        wait_ibf(c);
        check("R7 unknown command consumed", 8'(c), 8'(DLY));
        repeat (4) @(negedge clk);
        status_is("R7 OBF stays clear", 8'h00);
        put(1'b0, 8'h30); put(1'b0, 8'h77);
        status_is("R7 trailing data no OBF", 8'h00);
        ram_read(8'h30, 8'h00, "R7 trailing data dropped");

        // R8 idle data bytes
        put(1'b0, 8'hFF); put(1'b0, 8'h99);
        status_is("R8 idle data no OBF", 8'h00);
        ram_read(8'hFF, 8'hC3, "R8 idle data dropped");

        repeat (4) @(negedge clk);
        check("R4 queue drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule